// File: doc/BRIEF.md
# Capture and Reload Timer with Baud Tick

This block is a 16-bit timer/counter peripheral sitting behind a small byte-wide register port. The counter advances on every clock cycle, or on each falling edge of an external count pin, while a run bit is set. An external trigger pin, once its falling edge is enabled, either snapshots the running count into a capture register or forces the count back to a software-programmed reload value. Which of the two happens is picked by a single control bit.

When software selects the block as a bit-rate source for a serial receiver or transmitter, the counter always reloads on wrap-around, the overflow flag stays quiet, and every wrap produces a one-cycle baud tick. Two sticky flags (overflow and external trigger) feed a level interrupt request that is gated by an enable input.

Top module: `cap_rld_timer`

## Requirements
- R1: After reset every register reads 0 (control, reload, capture, count) and the outputs irq, ovf_flag, ext_flag, baud_tick, rx_clk_sel and tx_clk_sel are 0.
- R2: Address 0 is the control byte: bit 7 overflow flag, bit 6 external flag, bit 5 receive-clock select, bit 4 transmit-clock select, bit 3 trigger enable, bit 2 run, bit 1 count-source select, bit 0 capture-mode select. Addresses 1/2 are reload low/high, 3/4 capture low/high (read only), 5/6 count low/high; reads are combinational and written values read back; rx_clk_sel and tx_clk_sel mirror bits 5 and 4.
- R3: With run=1 and count-source select 0 the count rises by one each clock; with run=0 it holds.
- R4: With count-source select 1 the count rises by exactly one per falling edge on cnt_in (after a two-flop synchronizer) and holds while cnt_in is idle.
- R5: A count step from 16'hFFFF sets the overflow flag; it remains set until software writes 0 to bit 7.
- R6: Outside baud use, a wrap loads the reload value when capture-mode select is 0 and gives 0 when it is 1.
- R7: With trigger enable 1 and capture-mode select 1, a falling trig_in edge copies the count into the capture register and sets the external flag; the count is not disturbed.
- R8: With trigger enable 1 and capture-mode select 0, a falling trig_in edge loads the reload value into the count and sets the external flag.
- R9: With trigger enable 0, trig_in edges change neither flag, capture register nor count.
- R10: When bit 5 or bit 4 is 1, a wrap always loads the reload value whatever capture-mode select says, the overflow flag is not set, and baud_tick is high for exactly one cycle; trig_in edges then set the external flag but cause no capture or reload.
- R11: irq is 1 exactly when irq_en is 1 and the overflow or external flag is 1.
- R12: A flag set by hardware in the same cycle that software writes the control byte with that bit 0 stays set; writing 1 to a flag bit sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_in | input | 1 | External count pin, falling edges counted |
| trig_in | input | 1 | External trigger pin, falling edges act |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External trigger flag |
| baud_tick | output | 1 | One-cycle pulse per wrap in baud use |
| rx_clk_sel | output | 1 | Receive clock taken from this timer |
| tx_clk_sel | output | 1 | Transmit clock taken from this timer |

## Verification
A corrupted count shows up as a wrong readback at addresses 5/6 on the very next read, and as a wrap, flag or baud tick that arrives early, late or never; the bench reads the count at cycle-exact points so an off-by-one step is caught immediately. A wrong mode decode (capture versus reload, baud override) appears three cycles after a trigger edge as an unexpected capture value or count, and a lost or spurious flag appears one cycle after the wrap on ovf_flag and irq.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int BYTE_W = 8;

    // Control byte; field order fixes the bit positions software decodes.
    typedef struct packed {
        logic ovf;       // bit 7
        logic ext;       // bit 6
        logic rx_sel;    // bit 5
        logic tx_sel;    // bit 4
        logic trig_en;   // bit 3
        logic run;       // bit 2
        logic cnt_ext;   // bit 1
        logic cap_mode;  // bit 0
    } ctrl_t;

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], din};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall = st_q.prev & ~st_q.sh[STAGES-1];

    // R4: one event per edge
    assert_one_event_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/crt_regs.sv
module crt_regs
    import crt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr,
    input  logic  [BYTE_W-1:0] wdata,
    input  logic  hw_ovf_set,
    input  logic  hw_ext_set,
    output ctrl_t ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d = ctrl_t'(wdata);
        end
        // hardware sets win against a same-cycle software zero
        ctrl_d.ovf = ctrl_d.ovf | hw_ovf_set;
        ctrl_d.ext = ctrl_d.ext | hw_ext_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ovf && !ctrl_wr) |=> ctrl_q.ovf);

    assert_hw_set_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ovf_set || hw_ext_set) |=> (ctrl_q.ovf || !$past(hw_ovf_set)) && (ctrl_q.ext || !$past(hw_ext_set)));

endmodule

// File: rtl/crt_counter.sv
module crt_counter
    import crt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int BYTES = CNT_W / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] reload,
    input  logic [BYTES-1:0] cnt_wr_mask,
    input  logic [BYTE_W-1:0] wdata,
    input  logic             cnt_fall,
    input  logic             trig_fall,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             ovf_set,
    output logic             ext_set,
    output logic             baud_tick_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             btick;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic baud_mode;
    logic tick;
    logic wrap;
    logic trig_hit;
    logic wrap_reload;

    always_comb begin
        baud_mode   = ctrl.rx_sel | ctrl.tx_sel;
        tick        = ctrl.run & (ctrl.cnt_ext ? cnt_fall : 1'b1);
        wrap        = tick & (&st_q.cnt);
        trig_hit    = ctrl.trig_en & trig_fall;
        wrap_reload = baud_mode | ~ctrl.cap_mode;

        st_d       = st_q;
        st_d.btick = wrap & baud_mode;

        if (tick) begin
            if (wrap) begin
                st_d.cnt = wrap_reload ? reload : '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (trig_hit && !baud_mode) begin
            if (ctrl.cap_mode) begin
                st_d.cap = st_q.cnt;
            end else begin
                st_d.cnt = reload;
            end
        end

        for (int k = 0; k < BYTES; k++) begin
            if (cnt_wr_mask[k]) begin
                st_d.cnt[k*BYTE_W +: BYTE_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q     = st_q.cnt;
    assign cap_q       = st_q.cap;
    assign baud_tick_q = st_q.btick;
    assign ovf_set     = wrap & ~baud_mode;
    assign ext_set     = trig_hit;

    assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !(ctrl.trig_en && trig_fall) && cnt_wr_mask == '0) |=> $stable(count_q));

    assert_capture_only_on_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.trig_en && trig_fall) |=> $stable(cap_q));

    assert_baud_tick_in_baud_R10: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_q |-> $past(ctrl.rx_sel || ctrl.tx_sel));

    assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && wrap_reload && cnt_wr_mask == '0) |=> count_q == $past(reload));

endmodule

// File: rtl/cap_rld_timer.sv
module cap_rld_timer
    import crt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_in,
    input  logic              trig_in,
    input  logic              irq_en,
    output logic              irq,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick,
    output logic              rx_clk_sel,
    output logic              tx_clk_sel
);

    localparam int BYTES    = CNT_W / BYTE_W;
    localparam int RLD_BASE = 1;
    localparam int CAP_BASE = RLD_BASE + BYTES;
    localparam int CNT_BASE = CAP_BASE + BYTES;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_d, reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cap_q;
    logic [BYTES-1:0] cnt_wr_mask;
    logic             ctrl_wr;
    logic             cnt_fall;
    logic             trig_fall;
    logic             ovf_set;
    logic             ext_set;
    logic             btick;

    crt_edge_sync #(.STAGES(SYNC_STAGES)) i_cnt_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnt_in),
        .fall (cnt_fall)
    );

    crt_edge_sync #(.STAGES(SYNC_STAGES)) i_trig_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .fall (trig_fall)
    );

    crt_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wdata     (bus_wdata),
        .hw_ovf_set(ovf_set),
        .hw_ext_set(ext_set),
        .ctrl_q    (ctrl_q)
    );

    crt_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl_q),
        .reload     (reload_q),
        .cnt_wr_mask(cnt_wr_mask),
        .wdata      (bus_wdata),
        .cnt_fall   (cnt_fall),
        .trig_fall  (trig_fall),
        .count_q    (count_q),
        .cap_q      (cap_q),
        .ovf_set    (ovf_set),
        .ext_set    (ext_set),
        .baud_tick_q(btick)
    );

    // write decode and reload register
    always_comb begin
        ctrl_wr  = bus_wr && (int'(bus_addr) == 0);
        reload_d = reload_q;
        for (int k = 0; k < BYTES; k++) begin
            cnt_wr_mask[k] = bus_wr && (int'(bus_addr) == CNT_BASE + k);
            if (bus_wr && (int'(bus_addr) == RLD_BASE + k)) begin
                reload_d[k*BYTE_W +: BYTE_W] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            reload_q <= reload_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == 0) begin
            bus_rdata = ctrl_q;
        end
        for (int k = 0; k < BYTES; k++) begin
            if (int'(bus_addr) == RLD_BASE + k) bus_rdata = reload_q[k*BYTE_W +: BYTE_W];
            if (int'(bus_addr) == CAP_BASE + k) bus_rdata = cap_q[k*BYTE_W +: BYTE_W];
            if (int'(bus_addr) == CNT_BASE + k) bus_rdata = count_q[k*BYTE_W +: BYTE_W];
        end
    end

    assign ovf_flag   = ctrl_q.ovf;
    assign ext_flag   = ctrl_q.ext;
    assign rx_clk_sel = ctrl_q.rx_sel;
    assign tx_clk_sel = ctrl_q.tx_sel;
    assign baud_tick  = btick;
    assign irq        = irq_en & (ctrl_q.ovf | ctrl_q.ext);

    assert_irq_follows_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (ovf_flag || ext_flag)) |-> irq);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_no_ovf_in_baud_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(ctrl_wr && bus_wdata[7]) || !$past(rx_clk_sel || tx_clk_sel)));

endmodule

// File: tb/test_cap_rld_timer.sv
module test_cap_rld_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_in = 1'b1;
    logic       trig_in = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq, ovf_flag, ext_flag, baud_tick, rx_clk_sel, tx_clk_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cap_rld_timer i_cap_rld_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_in    (cnt_in),
        .trig_in   (trig_in),
        .irq_en    (irq_en),
        .irq       (irq),
        .ovf_flag  (ovf_flag),
        .ext_flag  (ext_flag),
        .baud_tick (baud_tick),
        .rx_clk_sel(rx_clk_sel),
        .tx_clk_sel(tx_clk_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling clock edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo, input logic [15:0] d);
        wr(lo, d[7:0]);
        wr(lo + 3'd1, d[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] d);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        d = {h, l};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trig_fall_now();
        trig_in = 1'b0;
        idle(3);
    endtask

    task automatic trig_release();
        trig_in = 1'b1;
        idle(3);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 register zero", v, 0);
        end
        chk("R1 outputs zero", {irq, ovf_flag, ext_flag, baud_tick, rx_clk_sel, tx_clk_sel}, 0);
    endtask

    task automatic t_regmap();
        logic [7:0]  v;
        logic [15:0] w;
        wr(0, 8'h1A);
        rd(0, v);
        chk("R2 control readback", v, 8'h1A);
        chk("R2 clock select pins", {rx_clk_sel, tx_clk_sel}, 2'b01);
        wr16(1, 16'hBEEF);
        rd16(1, w);
        chk("R2 reload readback", w, 16'hBEEF);
        wr(0, 8'h00);
    endtask

    task automatic t_timer_count();
        logic [15:0] w;
        wr16(5, 16'h0010);
        wr(0, 8'h04);
        rd16(5, w);
        chk("R3 start value", w, 16'h0010);
        idle(5);
        rd16(5, w);
        chk("R3 one per clock", w, 16'h0015);
        wr(0, 8'h00);
        idle(3);
        rd16(5, w);
        chk("R3 holds when stopped", w, 16'h0016);
    endtask

    task automatic t_ext_count();
        logic [15:0] w;
        wr16(5, 16'h0000);
        wr(0, 8'h06);
        idle(5);
        rd16(5, w);
        chk("R4 idle pin no count", w, 16'h0000);
        for (int p = 0; p < 3; p++) begin
            cnt_in = 1'b0;
            idle(4);
            cnt_in = 1'b1;
            idle(4);
        end
        rd16(5, w);
        chk("R4 one per falling edge", w, 16'h0003);
        wr(0, 8'h00);
    endtask

    task automatic t_reload_ovf();
        logic [15:0] w;
        logic [7:0]  v;
        wr16(1, 16'hFFF0);
        wr16(5, 16'hFFFD);
        wr(0, 8'h04);
        idle(3);
        rd16(5, w);
        chk("R6 wrap loads reload", w, 16'hFFF0);
        rd(0, v);
        chk("R5 overflow flag set", v, 8'h84);
        idle(5);
        chk("R5 flag sticky", ovf_flag, 1'b1);
        wr(0, 8'h00);
        rd(0, v);
        chk("R5 software clears flag", v, 8'h00);
    endtask

    task automatic t_capture_wrap();
        logic [15:0] w;
        wr16(5, 16'hFFFE);
        wr(0, 8'h05);
        idle(2);
        rd16(5, w);
        chk("R6 capture mode wraps to zero", w, 16'h0000);
        chk("R5 flag on wrap", ovf_flag, 1'b1);
        wr(0, 8'h00);
    endtask

    task automatic t_trig_capture();
        logic [15:0] w;
        wr16(5, 16'h1234);
        wr(0, 8'h09);
        trig_fall_now();
        rd16(3, w);
        chk("R7 capture value", w, 16'h1234);
        chk("R7 external flag", ext_flag, 1'b1);
        rd16(5, w);
        chk("R7 count undisturbed", w, 16'h1234);
        trig_release();
        wr(0, 8'h00);
    endtask

    task automatic t_trig_reload();
        logic [15:0] w;
        wr16(1, 16'hABCD);
        wr16(5, 16'h0005);
        wr(0, 8'h08);
        trig_fall_now();
        rd16(5, w);
        chk("R8 trigger reload", w, 16'hABCD);
        chk("R8 external flag", ext_flag, 1'b1);
        trig_release();
        wr(0, 8'h00);
    endtask

    task automatic t_trig_disabled();
        logic [15:0] w;
        wr16(5, 16'h0777);
        wr(0, 8'h01);
        trig_fall_now();
        rd16(3, w);
        chk("R9 capture unchanged", w, 16'h1234);
        rd16(5, w);
        chk("R9 count unchanged", w, 16'h0777);
        chk("R9 no external flag", ext_flag, 1'b0);
        trig_release();
        wr(0, 8'h00);
    endtask

    task automatic t_baud();
        logic [15:0] w;
        logic [7:0]  v;
        wr16(1, 16'hFFFC);
        wr16(5, 16'hFFFE);
        wr(0, 8'h25);
        idle(2);
        chk("R10 baud tick on wrap", baud_tick, 1'b1);
        rd16(5, w);
        chk("R10 forced reload", w, 16'hFFFC);
        rd(0, v);
        chk("R10 no overflow flag", v, 8'h25);
        chk("R10 rx select pin", rx_clk_sel, 1'b1);
        idle(1);
        chk("R10 tick lasts one cycle", baud_tick, 1'b0);
        wr(0, 8'h00);
        wr16(5, 16'h4444);
        wr(0, 8'h29);
        trig_fall_now();
        rd16(3, w);
        chk("R10 no capture in baud use", w, 16'h1234);
        rd16(5, w);
        chk("R10 no reload in baud use", w, 16'h4444);
        rd(0, v);
        chk("R10 external flag still set", v, 8'h69);
        trig_release();
        wr(0, 8'h00);
    endtask

    task automatic t_irq();
        wr(0, 8'h08);
        trig_fall_now();
        irq_en = 1'b0;
        #1;
        chk("R11 irq gated off", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R11 irq from flag", irq, 1'b1);
        trig_release();
        wr(0, 8'h00);
        chk("R11 irq drops with flags", irq, 1'b0);
        irq_en = 1'b0;
    endtask

    task automatic t_flag_race();
        logic [7:0] v;
        wr16(5, 16'hFFFE);
        wr(0, 8'h05);
        idle(1);
        wr(0, 8'h05);   // lands on the wrap edge with bit 7 = 0
        rd(0, v);
        chk("R12 hardware set survives write", v, 8'h85);
        wr(0, 8'h40);
        rd(0, v);
        chk("R12 software sets flag", v, 8'h40);
        wr(0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timer_count();
        t_ext_count();
        t_reload_ovf();
        t_capture_wrap();
        t_trig_capture();
        t_trig_reload();
        t_trig_disabled();
        t_baud();
        t_irq();
        t_flag_race();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule